// File: doc/BRIEF.md
# Cartridge Bus Wait-State Generator

This block sets the timing of every bus access. A 16-bit wait-control word is written into it, and each access that is presented is held busy for a number of cycles. That number depends on the 4-bit region, the access width (8/16-bit narrow or 32-bit wide), whether the access is sequential, whether it is a load or a store, and whether it is an instruction fetch served by the prefetch buffer. The block raises `rdy` in the last busy cycle.

Fixed regions use built-in wait counts. The three cartridge ROM windows (regions 8-9, 10-11 and 12-13) and the save-RAM window (regions 14-15) take their counts from fields of the control word. Until the first write of the control word, a built-in default table applies to every region. A separate combinational port gives the total cost of an N-word multiple transfer from any region. The cost uses the control word currently held.

Top module: `cart_wait_gen`

## Requirements
- R1: After reset, `busy` and `rdy` are low and the built-in default table (R2) applies until the first control write.
- R2: The default waits, given as narrow-nonseq/narrow-seq/wide-nonseq/wide-seq, are as follows. Region 2: 2/2/5/5. Regions 8,9: 4/2/7/5. Regions 10,11: 4/4/9/9. Regions 12,13: 4/8/13/17. Region 14: 4/4/9/9. All other regions: 0.
- R3: An access is accepted at a clock edge where `req_valid` is high and `busy` is low. A load keeps `busy` high for 2+wait cycles after that edge and a store for 1+wait cycles. `rdy` is high only in the last of those cycles. Requests presented while `busy` is high are ignored.
- R4: After a control write, a narrow non-sequential access to a cartridge window waits 4, 3, 2 or 8 cycles for codes 0 to 3. The codes sit in bits 3:2 (regions 8-9), 6:5 (regions 10-11) and 9:8 (regions 12-13).
- R5: A narrow sequential access to a cartridge window waits 1 cycle when its sequential bit is set. When the bit is clear it waits 2 for regions 8-9 (bit 4), 4 for regions 10-11 (bit 7) and 8 for regions 12-13 (bit 10).
- R6: A wide access to a cartridge window waits twice the window's narrow sequential wait plus one, whether it is sequential or not.
- R7: Regions 14 and 15 take the code in bits 1:0, with the same 4/3/2/8 mapping, for narrow accesses of either kind. A wide access waits twice that value plus one.
- R8: After a control write with bit 14 set, an instruction fetch from regions 8 to 13 waits 0 cycles. Fetches from other regions, and all fetches while bit 14 is clear, use the normal cost.
- R9: After a control write, region 2 keeps 2 (narrow) and 5 (wide) waits, and regions 0, 1 and 3 to 7 wait 0 cycles.
- R10: `burst_cost` equals 1 plus the region's wide non-sequential wait, plus (N-1) times (1 plus its wide sequential wait), for N = `burst_words` of at least 1. It is 0 when N is 0.
- R11: An access uses the control word held at its acceptance edge. A write at that same edge, or at any edge while the access is busy, affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the wait-control word |
| cfg_wdata | input | 16 | New wait-control word |
| req_valid | input | 1 | Access request |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 8/16-bit |
| req_seq | input | 1 | 1 = sequential access |
| req_fetch | input | 1 | 1 = instruction fetch through the prefetch buffer |
| req_store | input | 1 | 1 = store, 0 = load |
| busy | output | 1 | An access is in progress |
| rdy | output | 1 | Last cycle of the current access |
| burst_region | input | 4 | Start region of a multiple transfer |
| burst_words | input | BURST_W | Word count N of the multiple transfer |
| burst_cost | output | COST_W | Total cycles of the multiple transfer |

## Verification
A control write and the start of an access can land on the same clock edge. A write can also land while an access is counting down. The bench provokes the first case by asserting `cfg_wdata` with a code that changes the cycle count in the same cycle as `req_valid`. It provokes the second by writing at the second busy cycle of a long wide access. In both cases the measured length of `busy` up to `rdy` must match the old control word, and the access that follows must match the new one. The burst port is read in the same run and must follow the new word as soon as the write edge has passed.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    localparam int WAIT_W   = 5;
    localparam int REGION_W = 4;
    localparam int CTL_W    = 16;
    localparam int PF_BIT   = 14;

    localparam logic [REGION_W-1:0] RG_EXT_RAM    = 4'd2;
    localparam logic [REGION_W-1:0] RG_CART_FIRST = 4'd8;
    localparam logic [REGION_W-1:0] RG_CART_LAST  = 4'd13;
    localparam logic [REGION_W-1:0] RG_SAVE_A     = 4'd14;
    localparam logic [REGION_W-1:0] RG_SAVE_B     = 4'd15;

    typedef logic [WAIT_W-1:0]   wait_t;
    typedef logic [REGION_W-1:0] region_t;

    typedef struct packed {
        wait_t narrow_ns;
        wait_t narrow_sq;
        wait_t wide_ns;
        wait_t wide_sq;
    } wait_set_t;

    typedef struct packed {
        region_t region;
        logic    wide;
        logic    seq;
        logic    fetch;
        logic    store;
    } access_t;

    function automatic logic is_cart_window(region_t r);
        return (r >= RG_CART_FIRST) && (r <= RG_CART_LAST);
    endfunction

    function automatic wait_t code_to_wait(logic [1:0] code);
        wait_t w;
        case (code)
            2'd0:    w = wait_t'(4);
            2'd1:    w = wait_t'(3);
            2'd2:    w = wait_t'(2);
            default: w = wait_t'(8);
        endcase
        return w;
    endfunction

    function automatic wait_t seq_to_wait(logic [1:0] window, logic fast);
        wait_t w;
        if (fast) begin
            w = wait_t'(1);
        end else begin
            case (window)
                2'd0:    w = wait_t'(2);
                2'd1:    w = wait_t'(4);
                default: w = wait_t'(8);
            endcase
        end
        return w;
    endfunction

    function automatic wait_t double_plus_one(wait_t w);
        return wait_t'({w[WAIT_W-2:0], 1'b0} + 1'b1);
    endfunction

    function automatic wait_set_t make_set(int a, int b, int c, int d);
        wait_set_t s;
        s.narrow_ns = wait_t'(a);
        s.narrow_sq = wait_t'(b);
        s.wide_ns   = wait_t'(c);
        s.wide_sq   = wait_t'(d);
        return s;
    endfunction

    function automatic wait_set_t builtin_waits(region_t r);
        wait_set_t s;
        case (r)
            4'd2:        s = make_set(2, 2, 5, 5);
            4'd8, 4'd9:  s = make_set(4, 2, 7, 5);
            4'd10, 4'd11: s = make_set(4, 4, 9, 9);
            4'd12, 4'd13: s = make_set(4, 8, 13, 17);
            4'd14:       s = make_set(4, 4, 9, 9);
            default:     s = make_set(0, 0, 0, 0);
        endcase
        return s;
    endfunction

    function automatic wait_set_t decoded_waits(region_t r, logic [CTL_W-1:0] ctl);
        wait_set_t  s;
        logic [1:0] win;
        logic [1:0] ns_code;
        logic       sq_bit;
        wait_t      sq16;
        wait_t      sram;
        win = r[2:1] - 2'd0;
        case (win)
            2'd0:    begin ns_code = ctl[3:2]; sq_bit = ctl[4];  end
            2'd1:    begin ns_code = ctl[6:5]; sq_bit = ctl[7];  end
            default: begin ns_code = ctl[9:8]; sq_bit = ctl[10]; end
        endcase
        sq16 = seq_to_wait(win, sq_bit);
        sram = code_to_wait(ctl[1:0]);
        if (is_cart_window(r)) begin
            s.narrow_ns = code_to_wait(ns_code);
            s.narrow_sq = sq16;
            s.wide_ns   = double_plus_one(sq16);
            s.wide_sq   = double_plus_one(sq16);
        end else if (r == RG_SAVE_A || r == RG_SAVE_B) begin
            s.narrow_ns = sram;
            s.narrow_sq = sram;
            s.wide_ns   = double_plus_one(sram);
            s.wide_sq   = double_plus_one(sram);
        end else if (r == RG_EXT_RAM) begin
            s = make_set(2, 2, 5, 5);
        end else begin
            s = make_set(0, 0, 0, 0);
        end
        return s;
    endfunction

endpackage

// File: rtl/cwg_cfg_reg.sv
module cwg_cfg_reg
    import cwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl,
    output logic             written
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            written <= 1'b0;
        end else if (we) begin
            ctl     <= wdata;
            written <= 1'b1;
        end
    end

    AST_CFG_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> (ctl == $past(wdata)) && written); // R11

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!we && written) |=> $stable(ctl)); // R11

endmodule

// File: rtl/cwg_wait_lut.sv
module cwg_wait_lut
    import cwg_pkg::*;
(
    input  region_t          region,
    input  logic [CTL_W-1:0] ctl,
    input  logic             written,
    output wait_set_t        waits
);

    wait_set_t from_table;
    wait_set_t from_ctl;

    always_comb begin
        from_table = builtin_waits(region);
        from_ctl   = decoded_waits(region, ctl);
        waits      = written ? from_ctl : from_table;
    end

endmodule

// File: rtl/cwg_access_timer.sv
module cwg_access_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] total,
    output logic             busy,
    output logic             rdy
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy   <= 1'b1;
                remain <= total - CNT_W'(1);
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign rdy = busy && (remain == '0);

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy && (remain == $past(total) - CNT_W'(1))); // R3

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        (busy && remain != '0) |=> busy && (remain == $past(remain) - CNT_W'(1))); // R11

    AST_RDY_ENDS: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !busy); // R3

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !busy && !rdy); // R1

endmodule

// File: rtl/cwg_burst_calc.sv
module cwg_burst_calc
    import cwg_pkg::*;
#(
    parameter int BURST_W = 5,
    parameter int COST_W  = 10
) (
    input  wait_set_t          waits,
    input  logic [BURST_W-1:0] words,
    output logic [COST_W-1:0]  cost
);

    logic [COST_W-1:0] first_cost;
    logic [COST_W-1:0] step_cost;
    logic [COST_W-1:0] rest_words;

    always_comb begin
        first_cost = COST_W'(waits.wide_ns) + COST_W'(1);
        step_cost  = COST_W'(waits.wide_sq) + COST_W'(1);
        rest_words = COST_W'(words) - COST_W'(1);
        if (words == '0) begin
            cost = '0;
        end else begin
            cost = first_cost + COST_W'(rest_words * step_cost);
        end
    end

    always_comb begin
        if (words != '0) begin
            AST_BURST_FLOOR: assert (cost >= COST_W'(words)); // R10
        end
    end

endmodule

// File: rtl/cart_wait_gen.sv
module cart_wait_gen
    import cwg_pkg::*;
#(
    parameter int BURST_W = 5,
    parameter int COST_W  = $clog2(18 * (1 << BURST_W) + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [15:0]        cfg_wdata,
    input  logic               req_valid,
    input  logic [3:0]         req_region,
    input  logic               req_wide,
    input  logic               req_seq,
    input  logic               req_fetch,
    input  logic               req_store,
    output logic               busy,
    output logic               rdy,
    input  logic [3:0]         burst_region,
    input  logic [BURST_W-1:0] burst_words,
    output logic [COST_W-1:0]  burst_cost
);

    localparam int CNT_W    = WAIT_W + 1;
    localparam int N_LOOKUP = 2;

    logic [CTL_W-1:0] ctl_q;
    logic             written_q;
    access_t          acc;
    region_t          lk_region [N_LOOKUP];
    wait_set_t        lk_set    [N_LOOKUP];
    logic             pf_hit;
    wait_t            acc_wait;
    logic [CNT_W-1:0] acc_total;

    cwg_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .ctl     (ctl_q),
        .written (written_q)
    );

    assign acc.region = req_region;
    assign acc.wide   = req_wide;
    assign acc.seq    = req_seq;
    assign acc.fetch  = req_fetch;
    assign acc.store  = req_store;

    assign lk_region[0] = acc.region;
    assign lk_region[1] = burst_region;

    for (genvar g = 0; g < N_LOOKUP; g++) begin : g_lookup
        cwg_wait_lut u_lut (
            .region  (lk_region[g]),
            .ctl     (ctl_q),
            .written (written_q),
            .waits   (lk_set[g])
        );
    end

    assign pf_hit = acc.fetch && !acc.store && written_q && ctl_q[PF_BIT]
                    && is_cart_window(acc.region);

    always_comb begin
        if (pf_hit) begin
            acc_wait = '0;
        end else begin
            case ({acc.wide, acc.seq})
                2'b00:   acc_wait = lk_set[0].narrow_ns;
                2'b01:   acc_wait = lk_set[0].narrow_sq;
                2'b10:   acc_wait = lk_set[0].wide_ns;
                default: acc_wait = lk_set[0].wide_sq;
            endcase
        end
        acc_total = CNT_W'(acc_wait) + (acc.store ? CNT_W'(1) : CNT_W'(2));
    end

    cwg_access_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .total     (acc_total),
        .busy      (busy),
        .rdy       (rdy)
    );

    cwg_burst_calc #(.BURST_W(BURST_W), .COST_W(COST_W)) u_burst (
        .waits (lk_set[1]),
        .words (burst_words),
        .cost  (burst_cost)
    );

    AST_PF_FETCH_FAST: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_fetch && !req_store && written_q && ctl_q[PF_BIT]
         && req_region >= RG_CART_FIRST && req_region <= RG_CART_LAST)
        |=> !rdy ##1 rdy); // R8

    AST_SHORT_STORE: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_store && req_region == 4'd0) |=> rdy); // R9

endmodule

// File: tb/test_cart_wait_gen.sv
module test_cart_wait_gen;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 5;
    localparam int CW = $clog2(18 * (1 << BW) + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_region = '0;
    logic          req_wide = 1'b0;
    logic          req_seq = 1'b0;
    logic          req_fetch = 1'b0;
    logic          req_store = 1'b0;
    logic          busy;
    logic          rdy;
    logic [3:0]    burst_region = '0;
    logic [BW-1:0] burst_words = '0;
    logic [CW-1:0] burst_cost;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    logic [15:0] ctl_m = '0;
    bit   cfgd_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_wait_gen #(.BURST_W(BW)) i_cart_wait_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
        .req_seq(req_seq), .req_fetch(req_fetch), .req_store(req_store),
        .busy(busy), .rdy(rdy), .burst_region(burst_region),
        .burst_words(burst_words), .burst_cost(burst_cost)
    );

    function automatic int m_wait(int rg, bit wide, bit seq, bit fetch,
                                  logic [15:0] c, bit cf);
        int dn16 [16] = '{0,0,2,0,0,0,0,0,4,4,4,4,4,4,4,0};
        int ds16 [16] = '{0,0,2,0,0,0,0,0,2,2,4,4,8,8,4,0};
        int dn32 [16] = '{0,0,5,0,0,0,0,0,7,7,9,9,13,13,9,0};
        int ds32 [16] = '{0,0,5,0,0,0,0,0,5,5,9,9,17,17,9,0};
        int codes [4] = '{4,3,2,8};
        int slow  [3] = '{2,4,8};
        if (!cf) begin
            if (wide) return seq ? ds32[rg] : dn32[rg];
            return seq ? ds16[rg] : dn16[rg];
        end
        if (rg >= 8 && rg <= 13) begin
            int w = (rg - 8) / 2;
            int nsc = int'((c >> (2 + 3 * w)) & 16'h3);
            int sb  = int'((c >> (4 + 3 * w)) & 16'h1);
            int s16 = (sb != 0) ? 1 : slow[w];
            if (fetch && c[14]) return 0;
            if (wide) return 2 * s16 + 1;
            return seq ? s16 : codes[nsc];
        end
        if (rg == 14 || rg == 15) begin
            int v = codes[int'(c[1:0])];
            return wide ? 2 * v + 1 : v;
        end
        if (rg == 2) return wide ? 5 : 2;
        return 0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        ctl_m = v; cfgd_m = 1;
    endtask

    task automatic run(int rg, bit wide, bit seq, bit fetch, bit store,
                       int wr_at, logic [15:0] wr_val, output int n);
        @(negedge clk);
        req_region = 4'(rg); req_wide = wide; req_seq = seq;
        req_fetch = fetch; req_store = store; req_valid = 1'b1;
        if (wr_at == 0) begin cfg_we = 1'b1; cfg_wdata = wr_val; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        cfg_we = (wr_at == 1);
        cfg_wdata = wr_val;
        while (!rdy && n < 64) begin
            @(negedge clk);
            n++;
            cfg_we = (wr_at == n);
        end
        cfg_we = 1'b0;
        @(negedge clk);
        if (wr_at >= 0) begin ctl_m = wr_val; cfgd_m = 1; end
    endtask

    task automatic acc_chk(string tag, int rg, bit wide, bit seq, bit fetch, bit store);
        int n;
        int exp = (store ? 1 : 2) + m_wait(rg, wide, seq, fetch, ctl_m, cfgd_m);
        run(rg, wide, seq, fetch, store, -1, '0, n);
        chk($sformatf("%s region=%0d wide=%0d seq=%0d fetch=%0d store=%0d",
                      tag, rg, wide, seq, fetch, store), n, exp);
    endtask

    task automatic burst_chk(string tag, int rg, int words);
        int exp;
        @(negedge clk);
        burst_region = 4'(rg); burst_words = BW'(words);
        #1;
        exp = (words == 0) ? 0 :
              1 + m_wait(rg, 1, 0, 0, ctl_m, cfgd_m)
                + (words - 1) * (1 + m_wait(rg, 1, 1, 0, ctl_m, cfgd_m));
        chk($sformatf("%s region=%0d words=%0d", tag, rg, words), int'(burst_cost), exp);
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 rdy after reset", int'(rdy), 0);
    endtask

    task automatic t_defaults;
        acc_chk("R2", 8, 0, 0, 0, 0);
        acc_chk("R2", 9, 0, 1, 0, 0);
        acc_chk("R2", 12, 1, 0, 0, 0);
        acc_chk("R2", 13, 1, 1, 0, 0);
        acc_chk("R2", 10, 1, 0, 0, 1);
        acc_chk("R2", 14, 1, 0, 0, 0);
        acc_chk("R2", 15, 0, 0, 0, 0);
        acc_chk("R2", 2, 1, 1, 0, 0);
        acc_chk("R2 fetch before write", 8, 0, 0, 1, 0);
        burst_chk("R2 R10 default burst", 12, 3);
    endtask

    task automatic t_nonseq_codes;
        for (int code = 0; code < 4; code++) begin
            logic [15:0] v = '0;
            v[3:2] = 2'(code); v[6:5] = 2'((code + 1) % 4); v[9:8] = 2'((code + 2) % 4);
            write_cfg(v);
            acc_chk("R4", 8, 0, 0, 0, 0);
            acc_chk("R4", 11, 0, 0, 0, 0);
            acc_chk("R4", 12, 0, 0, 0, 1);
        end
    endtask

    task automatic t_seq_bits;
        write_cfg(16'h0000);
        acc_chk("R5 slow", 9, 0, 1, 0, 0);
        acc_chk("R5 slow", 10, 0, 1, 0, 0);
        acc_chk("R5 slow", 13, 0, 1, 0, 0);
        write_cfg(16'h0490);
        acc_chk("R5 fast", 8, 0, 1, 0, 0);
        acc_chk("R5 fast", 11, 0, 1, 0, 0);
        acc_chk("R5 fast", 12, 0, 1, 0, 1);
        write_cfg(16'h0080);
        acc_chk("R5 mixed", 9, 0, 1, 0, 0);
        acc_chk("R5 mixed", 10, 0, 1, 0, 0);
    endtask

    task automatic t_wide;
        write_cfg(16'h0314);
        acc_chk("R6", 8, 1, 0, 0, 0);
        acc_chk("R6", 8, 1, 1, 0, 0);
        acc_chk("R6", 11, 1, 0, 0, 0);
        acc_chk("R6", 13, 1, 1, 0, 1);
    endtask

    task automatic t_save_ram;
        for (int code = 0; code < 4; code++) begin
            write_cfg(16'(code));
            acc_chk("R7", 14, 0, 0, 0, 0);
            acc_chk("R7", 15, 0, 1, 0, 1);
            acc_chk("R7", 14, 1, 1, 0, 0);
            acc_chk("R7", 15, 1, 0, 0, 0);
        end
    endtask

    task automatic t_prefetch;
        write_cfg(16'h4000);
        acc_chk("R8 on", 8, 0, 0, 1, 0);
        acc_chk("R8 on", 13, 1, 1, 1, 0);
        acc_chk("R8 save fetch", 14, 0, 0, 1, 0);
        acc_chk("R8 ram fetch", 2, 1, 0, 1, 0);
        acc_chk("R8 data read", 10, 0, 0, 0, 0);
        write_cfg(16'h0000);
        acc_chk("R8 off", 12, 0, 0, 1, 0);
    endtask

    task automatic t_other_regions;
        write_cfg(16'h0123);
        acc_chk("R9", 0, 0, 0, 0, 0);
        acc_chk("R9", 3, 1, 0, 0, 0);
        acc_chk("R9", 7, 1, 1, 0, 1);
        acc_chk("R9", 2, 0, 0, 0, 0);
        acc_chk("R9", 2, 1, 0, 0, 1);
    endtask

    task automatic t_burst;
        write_cfg(16'h0201);
        burst_chk("R10", 8, 1);
        burst_chk("R10", 10, 4);
        burst_chk("R10", 14, 7);
        burst_chk("R10", 2, 31);
        burst_chk("R10", 5, 9);
        burst_chk("R10 zero", 12, 0);
    endtask

    task automatic t_write_collision;
        int n;
        int exp;
        write_cfg(16'h0000);
        exp = 2 + m_wait(8, 0, 0, 0, ctl_m, cfgd_m);
        run(8, 0, 0, 0, 0, 0, 16'h000C, n);
        chk("R11 same-edge write", n, exp);
        acc_chk("R11 after same-edge write", 8, 0, 0, 0, 0);
        exp = 2 + m_wait(12, 1, 0, 0, ctl_m, cfgd_m);
        run(12, 1, 0, 0, 0, 2, 16'h040C, n);
        chk("R11 write while busy", n, exp);
        acc_chk("R11 after busy write", 12, 1, 0, 0, 0);
        burst_chk("R11 burst after write", 12, 2);
    endtask

    task automatic t_busy_ignore;
        int n;
        int exp;
        write_cfg(16'h0000);
        exp = 2 + m_wait(13, 1, 1, 0, ctl_m, cfgd_m);
        @(negedge clk);
        req_region = 4'd13; req_wide = 1; req_seq = 1; req_fetch = 0; req_store = 0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_region = 4'd0; req_store = 1'b1;
        n = 1;
        while (!rdy && n < 64) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk("R3 request while busy ignored", n, exp);
        @(negedge clk);
        chk("R3 idle after rdy", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_nonseq_codes();
        t_seq_bits();
        t_wide();
        t_save_ram();
        t_prefetch();
        t_other_regions();
        t_burst();
        t_write_collision();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule